// File: doc/BRIEF.md
# Transactional Data Cache with Conflict Detection

This block is a small direct-mapped data cache for one core that adds hardware support for memory transactions. The core opens a transaction, issues loads and stores, and then asks to commit or to abort. Each line keeps two flags: one marks the line as read inside the open transaction, and the other marks it as written. Speculative store data is kept in the line itself. A word written this way stays private to the transaction. It reaches the backing array only when a later eviction or snoop finds it committed and dirty.

Commit happens in two steps. First, a validate step requests exclusive ownership for every written line that is still held shared. Then a single cycle clears all flags and turns every written line dirty. Other cores' requests arrive on a snoop port. A snoop that overlaps the transaction in a read-write or write-write way aborts it. An abort drops every written line, clears all flags in one cycle, and pulses a checkpoint-restore strobe to the core. An eviction of a flagged line also aborts the transaction, and so does an explicit request. Each abort reports its own cause code. Line fills come from an internal backing array.

Top module: `txn_cache`

## Requirements
- R1: After reset, tx_status is 0 (idle), abort_cause is 0 (none), and busy, upg_req, rsp_valid, ckpt_take and ckpt_restore are all low.
- R2: Ops on req_op are 1 begin, 2 load, 3 store, 4 commit and 5 abort. Every accepted request gets exactly one single-cycle rsp_valid. A begin outside a transaction clears all flags, sets tx_status to 1 (active), clears abort_cause, and pulses ckpt_take in the same cycle as its response.
- R3: A load returns the line's word. A miss fills the line first, and busy stays high during the fill. The backing word at an address whose low 8 bits are a is 0xC0DE0000 | a. Inside a transaction, a load sets the line's read flag.
- R4: A store inside a transaction writes its data into the line and sets the write flag, and later loads in the same transaction return that data. A store outside a transaction changes nothing.
- R5: Commit (tx_status 2 while validating) raises upg_req with the full line address for each written line held shared, one at a time in ascending index order. Each line advances on upg_grant. Lines filled while fill_shared was low need no upgrade. When validation ends, the flags clear, the written data becomes committed, and tx_status becomes 3.
- R6: An explicit abort discards every written line and sets tx_status 4 and abort_cause 3. A later load returns the value the line held before the transaction. A committed dirty word overwritten inside the transaction is written back first.
- R7: An exclusive snoop (snp_excl high) that hits a line with either flag set aborts the transaction: ckpt_restore pulses, tx_status becomes 4 and abort_cause becomes 1.
- R8: A shared snoop on a line that is only in the read-set does not abort. A shared snoop on a line in the write-set does abort.
- R9: A load or store miss inside a transaction whose victim line holds a flag aborts the transaction with abort_cause 2. The request's response comes with ckpt_restore.
- R10: A conflicting snoop during validation, or in the same cycle as an accepted commit, cancels the commit. The commit's response carries ckpt_restore and the status reports a conflict abort.
- R11: After commit, an exclusive snoop to a committed line causes no abort. A dirty word goes back to the backing array, and a reload returns the committed value.
- R12: busy is high while upg_req is high, and rsp_valid never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request valid, held until rsp_valid |
| req_op | input | 3 | Request operation code |
| req_addr | input | 12 | Word address (tag and index) |
| req_wdata | input | 32 | Store data |
| fill_shared | input | 1 | Other holders share the line being filled |
| rsp_valid | output | 1 | Request completed (one cycle) |
| rsp_rdata | output | 32 | Load data |
| busy | output | 1 | Fill or validation in progress; core stalls |
| ckpt_take | output | 1 | Core saves its register checkpoint |
| ckpt_restore | output | 1 | Core restores its register checkpoint |
| tx_status | output | 3 | Transaction status |
| abort_cause | output | 2 | Reason for the last abort |
| upg_req | output | 1 | Exclusive-upgrade request to coherence fabric |
| upg_addr | output | 12 | Line address being upgraded |
| upg_grant | input | 1 | Upgrade granted |
| snp_valid | input | 1 | Incoming snoop valid |
| snp_excl | input | 1 | Snoop asks for exclusive ownership |
| snp_addr | input | 12 | Snoop line address |

## Verification
The interesting collision is an incoming snoop that lands while a commit is in progress. The bench provokes it in two ways. In the first, the snoop and the commit request are driven for the same clock edge. In the second, upgrade grants are withheld so that validation stalls with upg_req high, and the snoop arrives during that stall. In both cases the bench expects the commit's response to carry the restore pulse, the status to show a conflict abort, and a following load to return the pre-transaction word. A snoop issued right after a finished commit is judged the other way: it must cause no abort, and the committed value must survive.

// File: rtl/tmc_pkg.sv
package tmc_pkg;
    typedef enum logic [1:0] {ST_INV, ST_SHR, ST_EXC, ST_DRT} line_st_t;
    typedef enum logic [2:0] {
        TX_IDLE = 3'd0, TX_ACTIVE = 3'd1, TX_VALIDATING = 3'd2,
        TX_COMMITTED = 3'd3, TX_ABORTED = 3'd4
    } tx_st_t;
    typedef enum logic [1:0] {AC_NONE, AC_CONFLICT, AC_OVERFLOW, AC_EXPLICIT} cause_t;
    typedef enum logic [2:0] {
        OP_NOP = 3'd0, OP_BEGIN = 3'd1, OP_LOAD = 3'd2,
        OP_STORE = 3'd3, OP_COMMIT = 3'd4, OP_ABORT = 3'd5
    } op_t;
    typedef enum logic [1:0] {F_READY, F_FILL, F_VALIDATE} fsm_t;

    localparam logic [15:0] INIT_MARK = 16'hC0DE;

    function automatic logic [31:0] init_word(int unsigned a);
        return {INIT_MARK, 16'(a)};
    endfunction
endpackage

// File: rtl/tmc_backing.sv
module tmc_backing #(
    parameter int DATA_W = 32,
    parameter int MEM_AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MEM_AW-1:0] raddr,
    output logic [DATA_W-1:0] rdata,
    input  logic              wa_en,
    input  logic [MEM_AW-1:0] wa_addr,
    input  logic [DATA_W-1:0] wa_data,
    input  logic              wb_en,
    input  logic [MEM_AW-1:0] wb_addr,
    input  logic [DATA_W-1:0] wb_data
);
    localparam int DEPTH = 1 << MEM_AW;
    logic [DATA_W-1:0] mem [DEPTH];

    assign rdata = mem[raddr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= DATA_W'(tmc_pkg::init_word(i));
        end else begin
            if (wa_en) mem[wa_addr] <= wa_data;
            if (wb_en) mem[wb_addr] <= wb_data;
        end
    end
endmodule

// File: rtl/tmc_pick.sv
module tmc_pick #(
    parameter int N = 16,
    parameter int W = 4
) (
    input  logic [N-1:0] need,
    output logic         any,
    output logic [W-1:0] sel
);
    always_comb begin
        any = |need;
        sel = '0;
        for (int i = N - 1; i >= 0; i--) if (need[i]) sel = W'(i);
    end
endmodule

// File: rtl/txn_cache.sv
module txn_cache
    import tmc_pkg::*;
#(
    parameter int LINES  = 16,
    parameter int TAG_W  = 8,
    parameter int DATA_W = 32,
    parameter int MEM_AW = 8
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             req_valid,
    input  logic [2:0]                       req_op,
    input  logic [TAG_W+$clog2(LINES)-1:0]   req_addr,
    input  logic [DATA_W-1:0]                req_wdata,
    input  logic                             fill_shared,
    output logic                             rsp_valid,
    output logic [DATA_W-1:0]                rsp_rdata,
    output logic                             busy,
    output logic                             ckpt_take,
    output logic                             ckpt_restore,
    output logic [2:0]                       tx_status,
    output logic [1:0]                       abort_cause,
    output logic                             upg_req,
    output logic [TAG_W+$clog2(LINES)-1:0]   upg_addr,
    input  logic                             upg_grant,
    input  logic                             snp_valid,
    input  logic                             snp_excl,
    input  logic [TAG_W+$clog2(LINES)-1:0]   snp_addr
);
    localparam int IDX_W  = $clog2(LINES);
    localparam int ADDR_W = TAG_W + IDX_W;

    line_st_t           st_q  [LINES];
    logic [TAG_W-1:0]   tag_q [LINES];
    logic [DATA_W-1:0]  data_q[LINES];
    logic [LINES-1:0]   rd_q, wr_q;
    fsm_t               fsm_q;
    tx_st_t             status_q;
    cause_t             cause_q;
    logic               rsp_q, take_q, restore_q;
    logic [DATA_W-1:0]  rdata_q;

    // request and snoop decode
    op_t               op_c;
    logic [IDX_W-1:0]  idx, s_idx, pick;
    logic [TAG_W-1:0]  tag, s_tag;
    logic              hit, s_hit, s_conf, in_tx, accept, is_mem, need_any;
    logic              do_abort, wa_en, wb_en;
    cause_t            ab_cause;
    logic [LINES-1:0]  need_upg;
    logic [ADDR_W-1:0] victim_addr;
    logic [DATA_W-1:0] mem_rdata;

    assign op_c   = op_t'(req_op);
    assign idx    = req_addr[IDX_W-1:0];
    assign tag    = req_addr[ADDR_W-1:IDX_W];
    assign s_idx  = snp_addr[IDX_W-1:0];
    assign s_tag  = snp_addr[ADDR_W-1:IDX_W];
    assign hit    = (st_q[idx] != ST_INV) && (tag_q[idx] == tag);
    assign s_hit  = snp_valid && (st_q[s_idx] != ST_INV) && (tag_q[s_idx] == s_tag);
    assign in_tx  = (status_q == TX_ACTIVE) || (status_q == TX_VALIDATING);
    assign s_conf = s_hit && in_tx && (wr_q[s_idx] || (snp_excl && rd_q[s_idx]));
    assign accept = req_valid && (fsm_q == F_READY) && !rsp_q;
    assign is_mem = (op_c == OP_LOAD) || (op_c == OP_STORE);
    assign victim_addr = {tag_q[idx], idx};

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_need
            assign need_upg[g] = wr_q[g] && (st_q[g] == ST_SHR);
        end
    endgenerate

    tmc_pick #(.N(LINES), .W(IDX_W)) u_pick (.need(need_upg), .any(need_any), .sel(pick));

    always_comb begin
        do_abort = 1'b0;
        ab_cause = AC_NONE;
        if (s_conf) begin
            do_abort = 1'b1;
            ab_cause = AC_CONFLICT;
        end else if (accept && in_tx && op_c == OP_ABORT) begin
            do_abort = 1'b1;
            ab_cause = AC_EXPLICIT;
        end else if (accept && in_tx && is_mem && !hit && st_q[idx] != ST_INV
                     && (rd_q[idx] || wr_q[idx])) begin
            do_abort = 1'b1;
            ab_cause = AC_OVERFLOW;
        end
    end

    // dirty victim or overwritten committed word goes back before it is lost
    assign wa_en = accept && !do_abort && (st_q[idx] == ST_DRT)
                   && ((op_c == OP_LOAD && !hit) || (op_c == OP_STORE && in_tx));
    assign wb_en = s_hit && !s_conf && (st_q[s_idx] == ST_DRT);

    tmc_backing #(.DATA_W(DATA_W), .MEM_AW(MEM_AW)) u_mem (
        .clk(clk), .rst(rst),
        .raddr(req_addr[MEM_AW-1:0]), .rdata(mem_rdata),
        .wa_en(wa_en), .wa_addr(victim_addr[MEM_AW-1:0]), .wa_data(data_q[idx]),
        .wb_en(wb_en), .wb_addr(snp_addr[MEM_AW-1:0]), .wb_data(data_q[s_idx])
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LINES; i++) begin
                st_q[i]   <= ST_INV;
                tag_q[i]  <= '0;
                data_q[i] <= '0;
            end
            rd_q <= '0; wr_q <= '0;
            fsm_q <= F_READY; status_q <= TX_IDLE; cause_q <= AC_NONE;
            rsp_q <= 1'b0; take_q <= 1'b0; restore_q <= 1'b0; rdata_q <= '0;
        end else begin
            rsp_q <= 1'b0; take_q <= 1'b0; restore_q <= 1'b0;
            if (s_hit && !s_conf)
                st_q[s_idx] <= snp_excl ? ST_INV : ST_SHR;
            if (do_abort) begin
                for (int i = 0; i < LINES; i++) if (wr_q[i]) st_q[i] <= ST_INV;
                rd_q <= '0; wr_q <= '0;
                restore_q <= 1'b1;
                status_q  <= TX_ABORTED;
                cause_q   <= ab_cause;
                fsm_q     <= F_READY;
                rsp_q     <= (fsm_q != F_READY) || accept;
            end else begin
                unique case (fsm_q)
                    F_READY: if (accept) begin
                        unique case (op_c)
                            OP_BEGIN: begin
                                if (!in_tx) begin
                                    rd_q <= '0; wr_q <= '0; take_q <= 1'b1;
                                    status_q <= TX_ACTIVE; cause_q <= AC_NONE;
                                end
                                rsp_q <= 1'b1;
                            end
                            OP_LOAD, OP_STORE: begin
                                if (op_c == OP_STORE && !in_tx) rsp_q <= 1'b1;
                                else if (!hit) fsm_q <= F_FILL;
                                else if (op_c == OP_LOAD) begin
                                    rdata_q <= data_q[idx];
                                    if (in_tx) rd_q[idx] <= 1'b1;
                                    rsp_q <= 1'b1;
                                end else begin
                                    data_q[idx] <= req_wdata;
                                    wr_q[idx]   <= 1'b1;
                                    if (st_q[idx] == ST_DRT) st_q[idx] <= ST_EXC;
                                    rsp_q <= 1'b1;
                                end
                            end
                            OP_COMMIT: begin
                                if (in_tx) begin
                                    fsm_q <= F_VALIDATE; status_q <= TX_VALIDATING;
                                end else rsp_q <= 1'b1;
                            end
                            default: rsp_q <= 1'b1;
                        endcase
                    end
                    F_FILL: begin
                        tag_q[idx]  <= tag;
                        data_q[idx] <= mem_rdata;
                        st_q[idx]   <= fill_shared ? ST_SHR : ST_EXC;
                        fsm_q       <= F_READY;
                    end
                    F_VALIDATE: begin
                        if (need_any) begin
                            if (upg_grant) st_q[pick] <= ST_EXC;
                        end else begin
                            for (int i = 0; i < LINES; i++) if (wr_q[i]) st_q[i] <= ST_DRT;
                            rd_q <= '0; wr_q <= '0;
                            status_q <= TX_COMMITTED;
                            fsm_q <= F_READY;
                            rsp_q <= 1'b1;
                        end
                    end
                    default: fsm_q <= F_READY;
                endcase
            end
        end
    end

    assign rsp_valid    = rsp_q;
    assign rsp_rdata    = rdata_q;
    assign busy         = fsm_q != F_READY;
    assign ckpt_take    = take_q;
    assign ckpt_restore = restore_q;
    assign tx_status    = status_q;
    assign abort_cause  = cause_q;
    assign upg_req      = (fsm_q == F_VALIDATE) && need_any;
    assign upg_addr     = {tag_q[pick], pick};
endmodule

// File: rtl/txn_cache_chk.sv
module txn_cache_chk
    import tmc_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       upg_req,
    input logic       rsp_valid,
    input logic       ckpt_take,
    input logic       ckpt_restore,
    input logic [2:0] tx_status,
    input logic [1:0] abort_cause
);
    // R12
    upg_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        upg_req |-> busy);
    // R12
    rsp_single_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);
    // R2
    take_active_chk: assert property (@(posedge clk) disable iff (rst)
        ckpt_take |-> (tx_status == TX_ACTIVE && !ckpt_restore));
    // R7
    restore_aborted_chk: assert property (@(posedge clk) disable iff (rst)
        ckpt_restore |-> tx_status == TX_ABORTED);
    // R6
    cause_match_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_status == TX_ABORTED) == (abort_cause != AC_NONE));
endmodule

bind txn_cache txn_cache_chk u_chk (
    .clk(clk), .rst(rst), .busy(busy), .upg_req(upg_req), .rsp_valid(rsp_valid),
    .ckpt_take(ckpt_take), .ckpt_restore(ckpt_restore),
    .tx_status(tx_status), .abort_cause(abort_cause)
);

// File: tb/sim_txn_cache.sv
module sim_txn_cache;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0, rst = 1'b1;
    logic        req_valid = 1'b0, fill_shared = 1'b0;
    logic [2:0]  req_op = '0;
    logic [11:0] req_addr = '0, upg_addr, snp_addr = '0;
    logic [31:0] req_wdata = '0, rsp_rdata;
    logic        rsp_valid, busy, ckpt_take, ckpt_restore, upg_req;
    logic        upg_grant = 1'b0, snp_valid = 1'b0, snp_excl = 1'b0;
    logic [2:0]  tx_status;
    logic [1:0]  abort_cause;

    int n_tests = 0, n_fail = 0;
    logic [31:0] rd_cap;
    logic tk_cap, rs_cap, busy_seen, sn_rs, auto_grant = 1'b1;
    int upg_cnt = 0;
    logic [11:0] upg_log [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    txn_cache u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
        .req_wdata(req_wdata), .fill_shared(fill_shared), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .busy(busy), .ckpt_take(ckpt_take), .ckpt_restore(ckpt_restore),
        .tx_status(tx_status), .abort_cause(abort_cause), .upg_req(upg_req), .upg_addr(upg_addr),
        .upg_grant(upg_grant), .snp_valid(snp_valid), .snp_excl(snp_excl), .snp_addr(snp_addr)
    );

    // coherence side: grant upgrades and log their addresses
    always @(negedge clk) begin
        if (upg_req && auto_grant) begin
            upg_grant = 1'b1;
            if (upg_cnt < 4) upg_log[upg_cnt] = upg_addr;
            upg_cnt++;
        end else upg_grant = 1'b0;
    end

    function automatic logic [31:0] iv(logic [11:0] a);
        return {16'hC0DE, 8'h00, a[7:0]};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_req(logic [2:0] op, logic [11:0] a, logic [31:0] d);
        int n;
        logic got;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
        n = 0; got = 1'b0; busy_seen = 1'b0;
        while (!got && n < 60) begin
            @(negedge clk);
            n++;
            if (busy) busy_seen = 1'b1;
            if (rsp_valid) begin
                got = 1'b1; rd_cap = rsp_rdata; tk_cap = ckpt_take; rs_cap = ckpt_restore;
            end
        end
        req_valid = 1'b0;
        if (!got) check("R2 response missing", 32'd0, 32'd1);
    endtask

    task automatic snoop_pulse(logic [11:0] a, logic ex);
        @(negedge clk);
        snp_valid = 1'b1; snp_addr = a; snp_excl = ex;
        @(negedge clk);
        sn_rs = ckpt_restore;
        snp_valid = 1'b0;
    endtask

    typedef struct packed {
        logic [2:0]  op;
        logic [11:0] addr;
        logic [31:0] wd;
        logic        chk;
        logic [31:0] exp;
        logic [2:0]  st;
    } vec_t;

    localparam vec_t TBL [13] = '{
        '{3'd1, 12'h000, 32'h0,        1'b0, 32'h0,        3'd1},
        '{3'd2, 12'h010, 32'h0,        1'b1, 32'hC0DE0010, 3'd1},
        '{3'd3, 12'h021, 32'h11111111, 1'b0, 32'h0,        3'd1},
        '{3'd2, 12'h021, 32'h0,        1'b1, 32'h11111111, 3'd1},
        '{3'd2, 12'h002, 32'h0,        1'b1, 32'hC0DE0002, 3'd1},
        '{3'd4, 12'h000, 32'h0,        1'b0, 32'h0,        3'd3},
        '{3'd2, 12'h021, 32'h0,        1'b1, 32'h11111111, 3'd3},
        '{3'd3, 12'h033, 32'h22222222, 1'b0, 32'h0,        3'd3},
        '{3'd2, 12'h033, 32'h0,        1'b1, 32'hC0DE0033, 3'd3},
        '{3'd1, 12'h000, 32'h0,        1'b0, 32'h0,        3'd1},
        '{3'd3, 12'h021, 32'h33333333, 1'b0, 32'h0,        3'd1},
        '{3'd5, 12'h000, 32'h0,        1'b0, 32'h0,        3'd4},
        '{3'd2, 12'h021, 32'h0,        1'b1, 32'h11111111, 3'd4}
    };

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 status", 32'(tx_status), 32'd0);
        check("R1 cause", 32'(abort_cause), 32'd0);
        check("R1 strobes", {27'd0, busy, upg_req, rsp_valid, ckpt_take, ckpt_restore}, 32'd0);

        // vector table: R2 R3 R4 R5 R6 along one flow
        upg_cnt = 0;
        for (int i = 0; i < 13; i++) begin
            do_req(TBL[i].op, TBL[i].addr, TBL[i].wd);
            if (TBL[i].chk) check($sformatf("R3/R4 table step %0d data", i), rd_cap, TBL[i].exp);
            check($sformatf("R2/R5/R6 table step %0d status", i), 32'(tx_status), 32'(TBL[i].st));
            if (i == 0) check("R2 take pulse", 32'(tk_cap), 32'd1);
            if (i == 1) check("R3 busy during fill", 32'(busy_seen), 32'd1);
        end
        check("R5 no upgrade for exclusive fill", 32'(upg_cnt), 32'd0);
        check("R6 explicit cause", 32'(abort_cause), 32'd3);

        // R9 overflow: second tag on a flagged index
        do_req(3'd1, 12'h000, 32'h0);
        do_req(3'd2, 12'h045, 32'h0);
        do_req(3'd2, 12'h055, 32'h0);
        check("R9 restore with response", 32'(rs_cap), 32'd1);
        check("R9 overflow cause", {29'd0, tx_status[0], abort_cause}, {29'd0, 1'b0, 2'd2});

        // R7 exclusive snoop on read-set line
        do_req(3'd1, 12'h000, 32'h0);
        do_req(3'd2, 12'h060, 32'h0);
        snoop_pulse(12'h060, 1'b1);
        check("R7 restore pulse", 32'(sn_rs), 32'd1);
        check("R7 status/cause", {27'd0, tx_status, abort_cause}, {27'd0, 3'd4, 2'd1});

        // R8 read-read sharing does not abort
        do_req(3'd1, 12'h000, 32'h0);
        do_req(3'd2, 12'h070, 32'h0);
        snoop_pulse(12'h070, 1'b0);
        check("R8 shared snoop no restore", 32'(sn_rs), 32'd0);
        check("R8 still active", 32'(tx_status), 32'd1);
        do_req(3'd4, 12'h000, 32'h0);
        check("R8 commit after sharing", 32'(tx_status), 32'd3);

        // R8 shared snoop on write-set line aborts and discards data
        do_req(3'd1, 12'h000, 32'h0);
        do_req(3'd3, 12'h080, 32'hDEADBEEF);
        snoop_pulse(12'h080, 1'b0);
        check("R8 shared snoop on written line", {27'd0, tx_status, abort_cause}, {27'd0, 3'd4, 2'd1});
        do_req(3'd2, 12'h080, 32'h0);
        check("R8 speculative data discarded", rd_cap, iv(12'h080));

        // R5 upgrades in index order for shared written lines
        do_req(3'd1, 12'h000, 32'h0);
        fill_shared = 1'b1;
        do_req(3'd3, 12'h091, 32'hA1A1A1A1);
        do_req(3'd3, 12'h0A2, 32'hA2A2A2A2);
        fill_shared = 1'b0;
        do_req(3'd3, 12'h0B3, 32'hA3A3A3A3);
        upg_cnt = 0;
        do_req(3'd4, 12'h000, 32'h0);
        check("R5 upgrade count", 32'(upg_cnt), 32'd2);
        check("R5 first upgrade addr", 32'(upg_log[0]), 32'h091);
        check("R5 second upgrade addr", 32'(upg_log[1]), 32'h0A2);
        check("R5 committed", 32'(tx_status), 32'd3);
        do_req(3'd2, 12'h0A2, 32'h0);
        check("R5 committed data", rd_cap, 32'hA2A2A2A2);

        // R10 conflicting snoop while validation is stalled
        auto_grant = 1'b0;
        do_req(3'd1, 12'h000, 32'h0);
        fill_shared = 1'b1;
        do_req(3'd3, 12'h0C4, 32'h5555AAAA);
        fill_shared = 1'b0;
        fork
            do_req(3'd4, 12'h000, 32'h0);
            begin
                int w;
                w = 0;
                do begin @(negedge clk); w++; end while (!upg_req && w < 40);
                check("R12 busy while upgrading", 32'(busy), 32'd1);
                check("R5 upgrade address", 32'(upg_addr), 32'h0C4);
                snp_valid = 1'b1; snp_addr = 12'h0C4; snp_excl = 1'b1;
                @(negedge clk);
                snp_valid = 1'b0;
            end
        join
        auto_grant = 1'b1;
        check("R10 commit response carries restore", 32'(rs_cap), 32'd1);
        check("R10 conflict abort", {27'd0, tx_status, abort_cause}, {27'd0, 3'd4, 2'd1});
        do_req(3'd2, 12'h0C4, 32'h0);
        check("R10 pre-transaction value", rd_cap, iv(12'h0C4));

        // R10 snoop in the same cycle as the commit request
        do_req(3'd1, 12'h000, 32'h0);
        do_req(3'd3, 12'h0E6, 32'h77777777);
        fork
            do_req(3'd4, 12'h000, 32'h0);
            snoop_pulse(12'h0E6, 1'b1);
        join
        check("R10 same-cycle commit cancelled", {31'd0, rs_cap}, 32'd1);
        check("R10 same-cycle cause", 32'(abort_cause), 32'd1);

        // R11 snoop after commit is a plain coherence request
        do_req(3'd1, 12'h000, 32'h0);
        do_req(3'd3, 12'h0D5, 32'h12345678);
        do_req(3'd4, 12'h000, 32'h0);
        snoop_pulse(12'h0D5, 1'b1);
        check("R11 no restore after commit", 32'(sn_rs), 32'd0);
        check("R11 status stays committed", 32'(tx_status), 32'd3);
        do_req(3'd2, 12'h0D5, 32'h0);
        check("R11 committed value written back", rd_cap, 32'h12345678);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule